// File: doc/BRIEF.md
# Multi-Standard Convolutional Encoder

This block is a feed-forward convolutional encoder with a streaming interface. A host sets a code mode and a block length and pulses `start`; the block then takes that many information bits, one per handshake, encodes each against the active generator set, and follows the data with zero tail bits. The tail drives the shift register back to all zeros, so every coded block ends in the zero state. The coded bits leave one per accepted output beat, and the final coded bit of the tail is flagged.

Three code modes share one 8-bit history register. Long mode has constraint length 9 and runs at rate 1/2 or rate 1/3. Short mode has constraint length 5 and always runs at rate 1/2. The intended use is as a bit-exact stimulus source for decoder verification, which is why every timing and selection rule below is deterministic.

Top module: `conv_stream_enc`

## Requirements
- R1: While reset is held and after its release, `idle` is 1 and both `out_valid` and `in_ready` are 0 until a block is started.
- R2: With `cfg_long`=1 and `cfg_third`=1, every input bit gives three coded bits from octal generators 557, 663 and 771, emitted in that order. A generator bit at position 8 taps the current input, and position 8-d taps the input d bits earlier. Each coded bit is the XOR of the tapped bits.
- R3: With `cfg_long`=1 and `cfg_third`=0, every input bit gives two coded bits from octal generators 561 then 753, using the tap convention of R2.
- R4: With `cfg_long`=0, the code has constraint length 5 and every input bit gives two coded bits from octal generators 23 then 33. Generator bit 4 taps the current input and bit 4-d taps the input d bits earlier. `cfg_third` has no effect in this mode.
- R5: After the last information bit, the block encodes 8 zero tail bits in long mode and 4 in short mode. A block of L bits at n coded bits per input therefore produces exactly n*(L+8) or n*(L+4) output beats.
- R6: The mode and the length are captured only on a `start` seen while `idle` is 1, and the history register is cleared at that moment. Changes to `cfg_long`, `cfg_third` or `cfg_len`, and further `start` pulses, during a block have no effect on that block.
- R7: `out_last` is 1 only on the final coded bit of the tail. After that beat is accepted, `idle` returns to 1.
- R8: A requested length above the mode's limit is saturated to 504 bits in long mode and to 334 bits in short mode.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_bit` and `out_last` hold their values on the next cycle.
- R10: `in_ready` is 1 only during the data phase of a block when no coded bit is pending. It is never 1 together with `out_valid`, so exactly one input bit is taken for each group of coded bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a block when `idle` is 1 |
| cfg_long | input | 1 | 1 selects constraint length 9, 0 selects constraint length 5 |
| cfg_third | input | 1 | 1 selects rate 1/3 in long mode |
| cfg_len | input | LEN_W (10) | Number of information bits in the block |
| in_data | input | 1 | Information bit |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Encoder accepts an information bit |
| out_bit | output | 1 | Coded bit |
| out_valid | output | 1 | `out_bit` is valid |
| out_ready | input | 1 | Sink accepts the coded bit |
| out_last | output | 1 | Final coded bit of the block |
| idle | output | 1 | No block in progress |

## Verification
An accepted input bit appears as the first coded bit of its group on `out_valid` one cycle after its handshake edge. Each following coded bit of the group is due one cycle after the previous beat is accepted. The next `in_ready` rises one cycle after the group's last beat. Tail groups begin one cycle after the previous group retires, and `idle` rises one cycle after the `out_last` beat. The bench builds the full expected coded sequence before each block starts and compares the outputs at every falling edge against the head of that sequence, so no check depends on a fixed latency. Hold and idle properties are checked against the value from the previous falling edge.

// File: rtl/conv_stream_enc.sv
module conv_stream_enc #(
  parameter int LEN_W = 10,
  parameter int MAX_LONG = 504,
  parameter int MAX_SHORT = 334,
  parameter logic [8:0] GL3_0 = 9'o557,
  parameter logic [8:0] GL3_1 = 9'o663,
  parameter logic [8:0] GL3_2 = 9'o771,
  parameter logic [8:0] GL2_0 = 9'o561,
  parameter logic [8:0] GL2_1 = 9'o753,
  parameter logic [4:0] GS_0 = 5'o23,
  parameter logic [4:0] GS_1 = 5'o33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_long,
  input  logic             cfg_third,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             out_bit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_last,
  output logic             idle
);
  localparam int HIST = 8;
  localparam int TAIL_LONG = 8;
  localparam int TAIL_SHORT = 4;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_TAIL} st_t;

  st_t            st;
  logic           m_long, m_third;
  logic [LEN_W-1:0] data_left;
  logic [3:0]     tail_left;
  logic [HIST-1:0] sr;
  logic           cur, hold;
  logic [1:0]     ph;
  logic [8:0]     gsel;
  logic [LEN_W-1:0] len_c;

  wire [1:0] last_ph = (m_long && m_third) ? 2'd2 : 2'd1;
  wire [8:0] win = {cur, sr};
  wire fire_out = hold && out_ready;
  wire grp_end = fire_out && (ph == last_ph);
  wire [LEN_W-1:0] lim = cfg_long ? LEN_W'(MAX_LONG) : LEN_W'(MAX_SHORT);

  assign len_c = (cfg_len > lim) ? lim : cfg_len;

  always_comb begin
    gsel = '0;
    if (m_long && m_third)
      case (ph)
        2'd0: gsel = GL3_0;
        2'd1: gsel = GL3_1;
        default: gsel = GL3_2;
      endcase
    else if (m_long)
      gsel = (ph == 2'd0) ? GL2_0 : GL2_1;
    else
      gsel = (ph == 2'd0) ? {GS_0, 4'b0} : {GS_1, 4'b0};
  end

  assign out_bit   = ^(win & gsel);
  assign out_valid = hold;
  assign in_ready  = (st == S_DATA) && !hold;
  assign out_last  = hold && (st == S_TAIL) && (tail_left == 4'd1) && (ph == last_ph);
  assign idle      = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      m_long <= 1'b0;
      m_third <= 1'b0;
      data_left <= '0;
      tail_left <= '0;
      sr <= '0;
      cur <= 1'b0;
      hold <= 1'b0;
      ph <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          m_long <= cfg_long;
          m_third <= cfg_long & cfg_third;
          sr <= '0;
          hold <= 1'b0;
          ph <= '0;
          tail_left <= cfg_long ? 4'(TAIL_LONG) : 4'(TAIL_SHORT);
          data_left <= len_c;
          st <= (len_c == '0) ? S_TAIL : S_DATA;
        end
        S_DATA: if (in_valid && in_ready) begin
          cur <= in_data;
          hold <= 1'b1;
          ph <= '0;
        end
        S_TAIL: if (!hold) begin
          cur <= 1'b0;
          hold <= 1'b1;
          ph <= '0;
        end
        default: st <= S_IDLE;
      endcase
      if (fire_out) begin
        if (grp_end) begin
          hold <= 1'b0;
          ph <= '0;
          sr <= {cur, sr[HIST-1:1]};
          if (st == S_DATA) begin
            data_left <= data_left - 1'b1;
            if (data_left == LEN_W'(1)) st <= S_TAIL;
          end else if (st == S_TAIL) begin
            tail_left <= tail_left - 1'b1;
            if (tail_left == 4'd1) st <= S_IDLE;
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) idle |-> !out_valid && !in_ready); // R1
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (st == S_TAIL && out_valid) |-> !cur); // R5
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!idle && !$past(idle)) |-> ($stable(m_long) && $stable(m_third))); // R6
  AST_LAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_ready && out_last) |=> idle); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last))); // R9
  AST_IN_GATED: assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> (!out_valid && !idle)); // R10
endmodule

// File: tb/conv_stream_enc_test.sv
`timescale 1ns/1ps
module conv_stream_enc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cfg_long = 1'b0, cfg_third = 1'b0;
  logic [9:0] cfg_len = '0;
  logic in_data = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_bit, out_valid, out_last, idle;

  int total = 0, bad = 0, n_out = 0;
  bit exp_b[$];
  bit exp_l[$];
  bit dbits[$];
  string tag = "R2";
  bit bp_on = 1'b0;
  logic [15:0] lf = 16'hACE1;
  logic pv = 1'b0, pr = 1'b0, pb = 1'b0, pl = 1'b0;
  logic [15:0] dseed = 16'h1D2F;

  always #2 clk = ~clk;

  conv_stream_enc uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_long(cfg_long), .cfg_third(cfg_third),
    .cfg_len(cfg_len), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_bit(out_bit), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .idle(idle)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr) begin
        check(out_valid && out_bit == pb && out_last == pl, "R9", {out_valid, out_bit, out_last}, {1'b1, pb, pl});
      end
      if (in_ready) check(!out_valid, "R10", out_valid, 0);
      if (out_valid) begin
        if (exp_b.size() == 0) check(1'b0, tag, out_bit, -1);
        else check(out_bit == exp_b[0] && out_last == exp_l[0], tag, {out_bit, out_last}, {exp_b[0], exp_l[0]});
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      out_ready = bp_on ? (lf[0] | lf[3]) : 1'b1;
      if (out_valid && out_ready) begin
        n_out++;
        if (exp_b.size() != 0) begin
          void'(exp_b.pop_front());
          void'(exp_l.pop_front());
        end
      end
      pv = out_valid; pr = out_ready; pb = out_bit; pl = out_last;
    end
  end

  task automatic build(input bit lng, input bit thr, input int len);
    int k, n, hist, win;
    int g[3];
    k = lng ? 9 : 5;
    n = (lng && thr) ? 3 : 2;
    if (lng && thr) begin g[0] = 'o557; g[1] = 'o663; g[2] = 'o771; end
    else if (lng) begin g[0] = 'o561; g[1] = 'o753; g[2] = 0; end
    else begin g[0] = 'o23; g[1] = 'o33; g[2] = 0; end
    hist = 0;
    for (int i = 0; i < len + k - 1; i++) begin
      bit b;
      b = (i < len) ? dbits[i] : 1'b0;
      win = (int'(b) << (k - 1)) | hist;
      for (int j = 0; j < n; j++) begin
        exp_b.push_back(^(win & g[j]));
        exp_l.push_back(i == len + k - 2 && j == n - 1);
      end
      hist = (hist >> 1) | (int'(b) << (k - 2));
    end
  endtask

  task automatic run_block(input bit lng, input bit thr, input int req_len, input string t,
                           input bit bp, input bit disturb);
    int len, n, want;
    bit acc;
    len = lng ? ((req_len > 504) ? 504 : req_len) : ((req_len > 334) ? 334 : req_len);
    n = (lng && thr) ? 3 : 2;
    dbits.delete();
    for (int i = 0; i < len; i++) begin
      dseed = {dseed[14:0], dseed[15] ^ dseed[14] ^ dseed[12] ^ dseed[3]};
      dbits.push_back(dseed[0]);
    end
    build(lng, thr, len);
    want = exp_b.size();
    tag = t;
    bp_on = bp;
    n_out = 0;
    @(negedge clk);
    cfg_long = lng; cfg_third = thr; cfg_len = 10'(req_len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      cfg_long = ~lng; cfg_third = ~thr; cfg_len = 10'd3;
    end
    for (int i = 0; i < len; i++) begin
      in_data = dbits[i];
      in_valid = 1'b1;
      if (disturb && i == 10) start = 1'b1;
      do begin
        acc = in_ready;
        @(negedge clk);
      end while (!acc);
      in_valid = 1'b0;
      start = 1'b0;
      if (i % 7 == 3) @(negedge clk);
    end
    while (!(idle && exp_b.size() == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
    check(n_out == want, "R5", n_out, want);
    check(idle == 1'b1 && out_valid == 1'b0, "R7", {idle, out_valid}, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(idle && !out_valid && !in_ready, "R1", {idle, out_valid, in_ready}, 4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(idle && !out_valid && !in_ready, "R1", {idle, out_valid, in_ready}, 4);
    run_block(1'b1, 1'b1, 20,   "R2", 1'b0, 1'b0);
    run_block(1'b1, 1'b1, 45,   "R2", 1'b1, 1'b0);
    run_block(1'b1, 1'b0, 37,   "R3", 1'b1, 1'b0);
    run_block(1'b0, 1'b1, 224,  "R4", 1'b0, 1'b0);
    run_block(1'b0, 1'b0, 290,  "R6", 1'b1, 1'b1);
    run_block(1'b1, 1'b0, 60,   "R6", 1'b0, 1'b1);
    run_block(1'b1, 1'b1, 600,  "R8", 1'b1, 1'b0);
    run_block(1'b0, 1'b0, 1000, "R8", 1'b0, 1'b0);
    run_block(1'b1, 1'b0, 1,    "R5", 1'b1, 1'b0);
    run_block(1'b0, 1'b0, 2,    "R7", 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule